// File: doc/BRIEF.md
# Overvoltage Latch and Power-Good Monitor

This block sits between the core-voltage comparators of a multi-phase buck controller and its PWM output stage. It receives three digitised comparator flags (core above the overvoltage trip, core below the release level, core below the undervoltage level), a soft-start-complete flag and a supply-healthy flag. From these it drives a power-good status output and a two-bit override request that the PWM output stage obeys ahead of any mode requested by the start-up sequencer.

An overvoltage event sets a sticky latch. While the latch is set, the override clamps the PWM outputs low whenever the core is above the trip level, which lets the lower switches shunt the core to ground. It switches them to three-state once the core drops below the release level, and keeps its last choice between the two levels. A persistent fault therefore cycles the outputs as a hysteretic shunt. Only a drop of the supply-healthy flag clears the latch. Undervoltage only pulls power-good low and is not remembered. The comparator flags are resynchronised before use.

Top module: `core_guard`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, pgood is 0 and pwm_ovr is 2'b00.
- R2: pwm_ovr uses 2'b00 for no override, 2'b01 for forcing the PWM outputs low and 2'b10 for three-state. 2'b11 never appears.
- R3: Each comparator flag passes through SYNC_STAGES flip-flops (default 2). A flag value present at a clock edge affects the registered outputs at the edge SYNC_STAGES edges later. With the default, an input set before edge E shows at the outputs after edge E+2.
- R4: When the latch is clear and the synchronised ov_above is 1, the latch sets and pwm_ovr becomes 2'b01. A one-cycle pulse on ov_above is enough.
- R5: While latched, a synchronised rel_below of 1 with ov_above of 0 makes pwm_ovr 2'b10.
- R6: While latched, a synchronised ov_above of 1 makes pwm_ovr 2'b01, even if rel_below is also 1.
- R7: While latched with both ov_above and rel_below at 0, pwm_ovr keeps its previous value.
- R8: The latch is cleared only when por_good is 0 at a clock edge. pwm_ovr then reads 2'b00 after that edge and stays 2'b00 until a new overvoltage arrives. Clearing ov_above, rel_below or uv_below does not clear it.
- R9: pgood is 1 only if, at the previous edge, por_good and ss_done were 1, the synchronised ov_above and uv_below were 0, and the latch was clear.
- R10: Undervoltage pulls pgood low without latching. pwm_ovr stays 2'b00, and pgood recovers once uv_below clears.
- R11: If por_good is 0 at the same edge where a synchronised overvoltage first arrives, the clear wins and the latch stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_good | input | 1 | Supply healthy; a 0 clears the overvoltage latch |
| ss_done | input | 1 | Soft-start has completed |
| ov_above | input | 1 | Asynchronous comparator flag: core above overvoltage trip |
| rel_below | input | 1 | Asynchronous comparator flag: core below release level |
| uv_below | input | 1 | Asynchronous comparator flag: core below undervoltage level |
| pgood | output | 1 | Power-good status |
| pwm_ovr | output | 2 | Override request to PWM outputs (00 none, 01 low, 10 three-state) |

## Verification
Two functions can fall in the same clock edge: a newly synchronised overvoltage trying to set the latch, and a supply-healthy drop clearing it. The bench provokes this with a one-cycle overvoltage pulse. It times por_good low for exactly the edge at which the pulse leaves the synchroniser. It then expects the override to remain 2'b00 after por_good returns. The same collision between the force-low and three-state requests is provoked by raising both comparator flags together while latched, and force-low is expected to win.

// File: rtl/core_guard_pkg.sv
package core_guard_pkg;

   // override request presented to the PWM output stage
   typedef enum logic [1:0] {
      OVR_NONE = 2'b00,
      OVR_LOW  = 2'b01,
      OVR_TRI  = 2'b10
   } ovr_e;

   // index of each flag inside the synchroniser bus
   localparam int FLAG_OV  = 0;
   localparam int FLAG_REL = 1;
   localparam int FLAG_UV  = 2;
   localparam int NFLAGS   = 3;

endpackage

// File: rtl/cg_sync.sv
module cg_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("cg_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("cg_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stg
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= '0;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign dout = stg[LAST];

endmodule

// File: rtl/cg_ov_latch.sv
module cg_ov_latch
   import core_guard_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic por_good,
   input  logic ov_hit,
   input  logic rel_hit,
   output logic latched,
   output ovr_e mode
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latched <= 1'b0;
         mode    <= OVR_NONE;
      end else if (!por_good) begin
         // only a supply-healthy drop releases the latch
         latched <= 1'b0;
         mode    <= OVR_NONE;
      end else if (!latched) begin
         if (ov_hit) begin
            latched <= 1'b1;
            mode    <= OVR_LOW;
         end
      end else if (ov_hit) begin
         mode <= OVR_LOW;
      end else if (rel_hit) begin
         mode <= OVR_TRI;
      end
      // between the two levels the previous choice is held
   end

endmodule

// File: rtl/cg_pgood.sv
module cg_pgood (
   input  logic clk,
   input  logic rst_n,
   input  logic por_good,
   input  logic ss_done,
   input  logic ov_hit,
   input  logic uv_hit,
   input  logic latched,
   output logic pgood
);

   logic in_limits;

   assign in_limits = !ov_hit && !uv_hit && !latched;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pgood <= 1'b0;
      else        pgood <= por_good && ss_done && in_limits;
   end

endmodule

// File: rtl/core_guard.sv
module core_guard
   import core_guard_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_good,
   input  logic       ss_done,
   input  logic       ov_above,
   input  logic       rel_below,
   input  logic       uv_below,
   output logic       pgood,
   output logic [1:0] pwm_ovr
);

   logic [NFLAGS-1:0] flags_raw;
   logic [NFLAGS-1:0] flags_s;
   logic              latched;
   ovr_e              mode;

   assign flags_raw[FLAG_OV]  = ov_above;
   assign flags_raw[FLAG_REL] = rel_below;
   assign flags_raw[FLAG_UV]  = uv_below;

   cg_sync #(
      .WIDTH  (NFLAGS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (flags_raw),
      .dout  (flags_s)
   );

   cg_ov_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .por_good (por_good),
      .ov_hit   (flags_s[FLAG_OV]),
      .rel_hit  (flags_s[FLAG_REL]),
      .latched  (latched),
      .mode     (mode)
   );

   cg_pgood u_pg (
      .clk      (clk),
      .rst_n    (rst_n),
      .por_good (por_good),
      .ss_done  (ss_done),
      .ov_hit   (flags_s[FLAG_OV]),
      .uv_hit   (flags_s[FLAG_UV]),
      .latched  (latched),
      .pgood    (pgood)
   );

   assign pwm_ovr = mode;

endmodule

// File: rtl/core_guard_chk.sv
module core_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       por_good,
   input logic       ss_done,
   input logic       pgood,
   input logic [1:0] pwm_ovr
);

   // R2
   ovr_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_ovr != 2'b11);

   // R8
   por_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !por_good |=> (pwm_ovr == 2'b00 && !pgood));

   // R8
   latch_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_ovr != 2'b00 && por_good) |=> pwm_ovr != 2'b00);

   // R4
   entry_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pwm_ovr) == 2'b00 && pwm_ovr != 2'b00) |-> pwm_ovr == 2'b01);

   // R9
   pgood_no_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pgood |-> pwm_ovr == 2'b00);

   // R9
   pgood_rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pgood) |-> $past(ss_done && por_good));

endmodule

bind core_guard core_guard_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .por_good (por_good),
   .ss_done  (ss_done),
   .pgood    (pgood),
   .pwm_ovr  (pwm_ovr)
);

// File: tb/core_guard_tb.sv
module core_guard_tb;

   localparam int NSYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_good = 1'b0;
   logic       ss_done = 1'b0;
   logic       ov_above = 1'b0;
   logic       rel_below = 1'b0;
   logic       uv_below = 1'b0;
   logic       pgood;
   logic [1:0] pwm_ovr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   core_guard #(.SYNC_STAGES(NSYNC)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .por_good  (por_good),
      .ss_done   (ss_done),
      .ov_above  (ov_above),
      .rel_below (rel_below),
      .uv_below  (uv_below),
      .pgood     (pgood),
      .pwm_ovr   (pwm_ovr)
   );

   // behavioural reference: delay line of flag samples plus latch state
   bit [2:0] hist[$];
   bit       m_lat;
   int       m_ovr;
   bit       m_pg;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist.delete();
         for (int i = 0; i < NSYNC; i++) hist.push_back(3'b000);
         m_lat = 0;
         m_ovr = 0;
         m_pg  = 0;
      end else begin
         bit [2:0] d;
         bit ov_d, rel_d, uv_d, old_lat;
         d = hist.pop_front();
         hist.push_back({uv_below, rel_below, ov_above});
         ov_d  = d[0];
         rel_d = d[1];
         uv_d  = d[2];
         old_lat = m_lat;
         m_pg = por_good && ss_done && !ov_d && !uv_d && !old_lat;
         if (!por_good) begin
            m_lat = 0;
            m_ovr = 0;
         end else if (!m_lat) begin
            if (ov_d) begin
               m_lat = 1;
               m_ovr = 1;
            end
         end else if (ov_d) m_ovr = 1;
         else if (rel_d)    m_ovr = 2;
      end
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (!done) begin
         check("R9 pgood vs model", int'(pgood), int'(m_pg));
         check("R3 override vs model", int'(pwm_ovr), m_ovr);
         check("R2 code 11 unused", int'(pwm_ovr == 2'b11), 0);
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      wait_cyc(3);
      check("R1 reset pgood", int'(pgood), 0);
      check("R1 reset override", int'(pwm_ovr), 0);
      rst_n = 1'b1;
      wait_cyc(1);
      check("R1 after reset override", int'(pwm_ovr), 0);

      // power-good gating
      por_good = 1'b1;
      wait_cyc(4);
      check("R9 no soft-start done", int'(pgood), 0);
      ss_done = 1'b1;
      wait_cyc(1);
      check("R9 pgood one edge after ss_done", int'(pgood), 1);

      // undervoltage: three-edge latency, not latched
      uv_below = 1'b1;
      wait_cyc(2);
      check("R3 uv not yet through sync", int'(pgood), 1);
      wait_cyc(1);
      check("R10 uv drops pgood", int'(pgood), 0);
      check("R10 uv no override", int'(pwm_ovr), 0);
      uv_below = 1'b0;
      wait_cyc(4);
      check("R10 pgood recovers", int'(pgood), 1);

      // overvoltage latch and hysteretic shunt
      ov_above = 1'b1;
      wait_cyc(4);
      check("R4 latch forces low", int'(pwm_ovr), 1);
      check("R4 pgood low", int'(pgood), 0);
      ov_above = 1'b0;
      wait_cyc(4);
      check("R7 hold low in band", int'(pwm_ovr), 1);
      check("R8 latch survives ov clear", int'(pgood), 0);
      rel_below = 1'b1;
      wait_cyc(4);
      check("R5 release three-state", int'(pwm_ovr), 2);
      rel_below = 1'b0;
      wait_cyc(4);
      check("R7 hold three-state", int'(pwm_ovr), 2);
      ov_above = 1'b1;
      wait_cyc(4);
      check("R6 recycle to low", int'(pwm_ovr), 1);
      ov_above = 1'b0;
      rel_below = 1'b1;
      wait_cyc(4);
      check("R5 second release", int'(pwm_ovr), 2);
      ov_above = 1'b1;
      wait_cyc(4);
      check("R6 low wins over release", int'(pwm_ovr), 1);
      ov_above = 1'b0;
      rel_below = 1'b0;
      wait_cyc(4);
      check("R8 pgood stays low while latched", int'(pgood), 0);

      // clear by supply-healthy drop
      por_good = 1'b0;
      wait_cyc(1);
      check("R8 por clears override", int'(pwm_ovr), 0);
      por_good = 1'b1;
      wait_cyc(4);
      check("R8 stays clear", int'(pwm_ovr), 0);
      check("R8 pgood back", int'(pgood), 1);

      // one-cycle pulse latches
      ov_above = 1'b1;
      wait_cyc(1);
      ov_above = 1'b0;
      wait_cyc(3);
      check("R4 pulse latches", int'(pwm_ovr), 1);
      por_good = 1'b0;
      wait_cyc(1);
      por_good = 1'b1;
      wait_cyc(2);

      // collision: clear at the edge the synced pulse arrives
      ov_above = 1'b1;
      wait_cyc(1);
      ov_above = 1'b0;
      wait_cyc(1);
      por_good = 1'b0;
      wait_cyc(1);
      por_good = 1'b1;
      check("R11 clear beats arrival", int'(pwm_ovr), 0);
      wait_cyc(4);
      check("R11 no late latch", int'(pwm_ovr), 0);
      check("R11 pgood returns", int'(pgood), 1);

      wait_cyc(2);
      finish_run();
   end

endmodule